// File: doc/BRIEF.md
# Sticky Status and Interrupt Controller

This block holds a 24-bit status word and a 24-bit enable mask, and drives a single interrupt line toward a host. Event sources elsewhere in the chip raise single-cycle strobes that set status bits. A status bit stays set until the host writes a 1 to that position. The interrupt line is active while any enabled status bit is active. The line can run as a level in either polarity. It can also run as a fixed-width pulse in either direction, fired by each new rise of the enabled condition.

Two status positions follow special rules. Bit 0 flags a rejected host command and is active low. It resets to 1 and falls on a bad-command strobe. Host writes cannot change it, and only a port re-initialisation strobe sets it again. Bit 5 is raised by an internal watchdog when the host has not read the energy result for a programmable number of clock periods. A host write can clear bit 5 only after such a read has taken place. The host port decoder is outside the block; it delivers write, read and command strobes on plain inputs.

Top module: `stirq_ctrl`

## Requirements
- R1: After reset the status word reads 0x000001, the mask reads 0x000000, and the interrupt line is at the idle level of the selected mode.
- R2: An event strobe sets its status bit whatever the mask holds. Settable positions are 23, 22, 21, 19, 17, 16, 15, 14, 13, 12, 11, 4, 3 and 2, and each bit becomes visible one clock after its strobe.
- R3: On a status write, each data bit equal to 1 clears the matching status bit, and each data bit equal to 0 leaves the matching status bit unchanged.
- R4: When an event strobe and a status write hit the same bit in one cycle, the bit ends up set.
- R5: Positions 20, 18, 10, 9, 8, 7, 6 and 1 always read 0 in both the status word and the mask. Event strobes on those positions, and on positions 0 and 5, have no effect.
- R6: Bit 0 goes to 0 on a bad-command strobe and ignores status writes. A port-init strobe returns it to 1, and port-init wins when both strobes arrive together.
- R7: The interrupt condition is true when some status bit is active and its mask bit is 1. Bit 0 counts as active when it is 0; every other bit counts as active when it is 1. A mask write takes effect one clock later.
- R8: Mode 2'b00 drives the line low while the condition holds and high otherwise. Mode 2'b01 drives it high while the condition holds and low otherwise.
- R9: In mode 2'b11 the line idles low, and in mode 2'b10 it idles high. Each rise of the condition produces one pulse of the opposite level, PULSE_W clocks long, that starts one clock after the condition rises. The condition staying true produces no further pulse.
- R10: Bit 5 is set once WDOG_LIMIT consecutive clocks have passed without an energy read. Each energy read restarts the count.
- R11: A status write with bit 5 equal to 1 clears bit 5 only if an energy read occurred in an earlier cycle after bit 5 was last set. Otherwise bit 5 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 24 | Event strobes, one per status position |
| bad_cmd | input | 1 | Strobe: host issued a rejected command |
| port_init | input | 1 | Strobe: host port re-initialisation |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 24 | Status write data (1 = clear) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 24 | Mask write data |
| energy_rd | input | 1 | Strobe: host read the energy result |
| irq_mode | input | 2 | Line signalling mode |
| status_q | output | 24 | Current status word |
| mask_q | output | 24 | Current mask word |
| irq_pin | output | 1 | Interrupt line |

## Verification
A wrong status bit shows on `status_q` one clock after the strobe or write that caused it. If the bit is enabled, the interrupt line also shows the error in the same cycle in the level modes, and one clock later in the pulse modes. A pulse counter that is off by one changes the pulse length, and this shows on the line within PULSE_W + 1 clocks of the rise. A watchdog count error moves the bit-5 set time away from the exact WDOG_LIMIT-th clock after the last read. The bench runs an independent model of these rules and compares every cycle, so the fault appears in the first compare after it.

// File: rtl/stirq_pkg.sv
package stirq_pkg;

    localparam int unsigned STAT_W      = 24;
    localparam int unsigned BIT_BADCMD  = 0;
    localparam int unsigned BIT_WDOG    = 5;

    // implemented status positions (reserved ones read 0)
    localparam logic [STAT_W-1:0] VALID_BITS = 24'hEBF83D;
    // positions an external event strobe may set
    localparam logic [STAT_W-1:0] EVENT_BITS = 24'hEBF81C;
    // the only active-low position
    localparam logic [STAT_W-1:0] LOW_ACTIVE = 24'h000001;

    typedef enum logic [1:0] {
        MODE_LVL_LO   = 2'b00,
        MODE_LVL_HI   = 2'b01,
        MODE_EDGE_LO  = 2'b10,
        MODE_EDGE_HI  = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] mask;
    } regs_t;

endpackage

// File: rtl/stirq_watchdog.sv
module stirq_watchdog #(
    parameter int unsigned LIMIT = 20_480_000,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic energy_rd,
    output logic expire,
    output logic clr_ok
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } wd_t;

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] SAT  = CW'(LIMIT);

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d   = wd_q;
        expire = 1'b0;
        if (energy_rd) begin
            wd_d.cnt = '0;
        end else if (wd_q.cnt == LAST) begin
            wd_d.cnt = SAT;
            expire   = 1'b1;
        end else if (wd_q.cnt < SAT) begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
        if (expire) begin
            wd_d.seen = 1'b0;
        end else if (energy_rd) begin
            wd_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign clr_ok = wd_q.seen;

    // R10: one expiry per quiet period
    a_r10_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    // R10: a read restarts the count, so no expiry right after it
    a_r10_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        energy_rd |=> !expire);
    // R11: clear permission is withdrawn when the bit is raised
    a_r11_perm_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !clr_ok);

endmodule

// File: rtl/stirq_status.sv
module stirq_status
    import stirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              bad_cmd,
    input  logic              port_init,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              wdog_expire,
    input  logic              wdog_clr_ok,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q
);

    localparam logic [STAT_W-1:0] WDOG_ONE = STAT_W'(1) << BIT_WDOG;
    localparam logic [STAT_W-1:0] CLR_BASE = VALID_BITS & ~LOW_ACTIVE;

    regs_t r_d, r_q;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;
    logic [STAT_W-1:0] clr_allow;

    always_comb begin
        r_d       = r_q;
        clr_allow = wdog_clr_ok ? CLR_BASE : (CLR_BASE & ~WDOG_ONE);
        set_v     = (evt_set & EVENT_BITS) | (wdog_expire ? WDOG_ONE : '0);
        clr_v     = stat_wr ? (stat_wdata & clr_allow) : '0;
        r_d.stat  = (r_q.stat & ~clr_v) | set_v;
        if (port_init) begin
            r_d.stat[BIT_BADCMD] = 1'b1;
        end else if (bad_cmd) begin
            r_d.stat[BIT_BADCMD] = 1'b0;
        end else begin
            r_d.stat[BIT_BADCMD] = r_q.stat[BIT_BADCMD];
        end
        if (mask_wr) begin
            r_d.mask = mask_wdata & VALID_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stat <= LOW_ACTIVE;
            r_q.mask <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign status_q = r_q.stat;
    assign mask_q   = r_q.mask;

    // R3: a written 1 on a plain event bit with no concurrent set leaves it clear
    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && evt_set == '0) |=> ((status_q & $past(stat_wdata & EVENT_BITS)) == '0));
    // R4: a set in the same cycle as a clear wins
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & EVENT_BITS) != '0) |=>
        ((status_q & $past(evt_set & EVENT_BITS)) == $past(evt_set & EVENT_BITS)));
    // R6: port init restores the active-low flag
    a_r6_init_restores: assert property (@(posedge clk) disable iff (!rst_n)
        port_init |=> status_q[BIT_BADCMD]);
    // R6: bad command drops the flag when no init arrives
    a_r6_badcmd_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cmd && !port_init) |=> !status_q[BIT_BADCMD]);
    // R11: no clear of the watchdog bit without a prior read
    a_r11_wdog_held: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[BIT_WDOG] && !wdog_clr_ok) |=> status_q[BIT_WDOG]);

endmodule

// File: rtl/stirq_pin.sv
module stirq_pin
    import stirq_pkg::*;
#(
    parameter int unsigned PULSE_W = 4,
    localparam int unsigned PW     = $clog2(PULSE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_q,
    input  logic [STAT_W-1:0] mask_q,
    input  logic [1:0]        irq_mode,
    output logic              irq_pin
);

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] left;
    } pin_t;

    pin_t p_d, p_q;
    logic cond;
    logic rise;
    logic pulsing;
    irq_mode_e mode;

    always_comb begin
        p_d    = p_q;
        cond   = |((status_q ^ LOW_ACTIVE) & mask_q);
        rise   = cond && !p_q.prev;
        p_d.prev = cond;
        if (rise) begin
            p_d.left = PW'(PULSE_W);
        end else if (p_q.left != '0) begin
            p_d.left = p_q.left - 1'b1;
        end
        pulsing = (p_q.left != '0);
        mode    = irq_mode_e'(irq_mode);
        unique case (mode)
            MODE_LVL_LO:  irq_pin = !cond;
            MODE_LVL_HI:  irq_pin = cond;
            MODE_EDGE_LO: irq_pin = !pulsing;
            MODE_EDGE_HI: irq_pin = pulsing;
            default:      irq_pin = !cond;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // R9: a rise of the condition starts a pulse on the next clock
    a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && irq_mode == 2'b11) |=> (irq_mode != 2'b11 || irq_pin));
    // R9: with no pending count and no rise, the line returns to idle
    a_r9_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.left <= PW'(1) && !rise && irq_mode == 2'b11) |=> (irq_mode != 2'b11 || !irq_pin));
    // R7: with an empty mask the level line never asserts
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && irq_mode == 2'b01) |-> !irq_pin);

endmodule

// File: rtl/stirq_ctrl.sv
module stirq_ctrl
    import stirq_pkg::*;
#(
    parameter int unsigned WDOG_LIMIT = 20_480_000,
    parameter int unsigned PULSE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              bad_cmd,
    input  logic              port_init,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              energy_rd,
    input  logic [1:0]        irq_mode,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_pin
);

    logic wdog_expire;
    logic wdog_clr_ok;

    stirq_watchdog #(
        .LIMIT (WDOG_LIMIT)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .energy_rd (energy_rd),
        .expire    (wdog_expire),
        .clr_ok    (wdog_clr_ok)
    );

    stirq_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_set     (evt_set),
        .bad_cmd     (bad_cmd),
        .port_init   (port_init),
        .stat_wr     (stat_wr),
        .stat_wdata  (stat_wdata),
        .mask_wr     (mask_wr),
        .mask_wdata  (mask_wdata),
        .wdog_expire (wdog_expire),
        .wdog_clr_ok (wdog_clr_ok),
        .status_q    (status_q),
        .mask_q      (mask_q)
    );

    stirq_pin #(
        .PULSE_W (PULSE_W)
    ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_mode (irq_mode),
        .irq_pin  (irq_pin)
    );

    // R5: reserved positions never show in either register
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | mask_q) & ~VALID_BITS) == '0);

endmodule

// File: tb/sim_stirq_ctrl.sv
module sim_stirq_ctrl;

    localparam int LIM = 40;
    localparam int PW  = 4;
    localparam logic [23:0] VALID = 24'hEBF83D;
    localparam logic [23:0] EVB   = 24'hEBF81C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_set = '0;
    logic        bad_cmd = 1'b0;
    logic        port_init = 1'b0;
    logic        stat_wr = 1'b0;
    logic [23:0] stat_wdata = '0;
    logic        mask_wr = 1'b0;
    logic [23:0] mask_wdata = '0;
    logic        energy_rd = 1'b0;
    logic [1:0]  irq_mode = 2'b00;
    logic [23:0] status_q;
    logic [23:0] mask_q;
    logic        irq_pin;

    stirq_ctrl #(.WDOG_LIMIT(LIM), .PULSE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bad_cmd(bad_cmd),
        .port_init(port_init), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .energy_rd(energy_rd),
        .irq_mode(irq_mode), .status_q(status_q), .mask_q(mask_q), .irq_pin(irq_pin)
    );

    always #10 clk = !clk;

    typedef struct {
        logic [23:0] s;
        logic [23:0] m;
        logic        p;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [23:0] ms = 24'h000001;
    logic [23:0] mm = '0;
    int  mcnt = 0;
    bit  mseen = 0;
    bit  mprev = 0;
    bit  mcond = 0;
    int  mpc = 0;

    function automatic bit cond_of(logic [23:0] s, logic [23:0] m);
        return |((s ^ 24'h000001) & m);
    endfunction

    // driver: called at a falling edge, covers exactly one rising edge
    task automatic step(input logic [23:0] evt, input bit inv, input bit init,
                        input bit wr, input logic [23:0] wd,
                        input bit mwr, input logic [23:0] md,
                        input bit erd, input string tag);
        bit fire;
        bit rise;
        logic [23:0] clr;
        logic [23:0] ns;
        exp_t e;
        evt_set = evt; bad_cmd = inv; port_init = init;
        stat_wr = wr; stat_wdata = wd; mask_wr = mwr; mask_wdata = md;
        energy_rd = erd;
        fire = 0;
        if (erd) mcnt = 0;
        else if (mcnt == LIM - 1) begin fire = 1; mcnt = LIM; end
        else if (mcnt < LIM) mcnt++;
        clr = wr ? (wd & VALID & ~24'h000001) : '0;
        if (!mseen) clr[5] = 1'b0;              // R11
        if (fire) mseen = 0; else if (erd) mseen = 1;
        rise = mcond && !mprev;
        mprev = mcond;
        mpc = rise ? PW : (mpc > 0 ? mpc - 1 : 0);
        ns = (ms & ~clr) | (evt & EVB);
        if (fire) ns[5] = 1'b1;                 // R10
        ns[0] = init ? 1'b1 : (inv ? 1'b0 : ms[0]);
        ms = ns;
        if (mwr) mm = md & VALID;
        mcond = cond_of(ms, mm);
        e.s = ms; e.m = mm; e.tag = tag;
        e.p = irq_mode[1] ? (irq_mode[0] ? (mpc != 0) : (mpc == 0))
                          : (irq_mode[0] ? mcond : !mcond);
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step('0, 0, 0, 0, '0, 0, '0, 0, tag);
    endtask

    task automatic swr(input logic [23:0] wd, input string tag);
        step('0, 0, 0, 1, wd, 0, '0, 0, tag);
    endtask

    // monitor: compares mid high phase, away from both edges
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (status_q !== e.s || mask_q !== e.m || irq_pin !== e.p) begin
                    errors++;
                    $display("FAIL %s: status %h mask %h pin %b, expected status %h mask %h pin %b",
                             e.tag, status_q, mask_q, irq_pin, e.s, e.m, e.p);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, mode 00 idles high
        checks++;
        if (status_q !== 24'h000001 || mask_q !== 24'h0 || irq_pin !== 1'b1) begin
            errors++;
            $display("FAIL R1: status %h mask %h pin %b, expected 000001 000000 1",
                     status_q, mask_q, irq_pin);
        end
        irq_mode = 2'b01;
        step('0, 0, 0, 0, '0, 1, 24'hFFFFFF, 0, "R7 mask all, R5 reserved mask");
        step(24'hFFFFFF, 0, 0, 0, '0, 0, '0, 1, "R2 R5 set all events");
        swr(24'h030000, "R3 clear two bits");
        swr(24'h000000, "R3 zero write keeps");
        swr(24'hFFFFFF, "R3 clear all");
        step(24'h000010, 0, 0, 1, 24'h000010, 0, '0, 0, "R4 set beats clear");
        step(24'h000022, 0, 0, 0, '0, 0, '0, 1, "R5 bits 1 and 5 not settable");
        step('0, 1, 0, 0, '0, 0, '0, 0, "R6 bad command");
        swr(24'h000001, "R6 write ignores bit0");
        step('0, 1, 1, 0, '0, 0, '0, 0, "R6 init wins");
        swr(24'hFFFFFF, "R3 clear");
        irq_mode = 2'b00;
        idle(2, "R8 low level idle");
        step(24'h800000, 0, 0, 0, '0, 0, '0, 1, "R8 low level active");
        step('0, 0, 0, 1, 24'hFFFFFF, 1, 24'h000004, 0, "R7 narrow mask");
        step(24'h000008, 0, 0, 0, '0, 0, '0, 0, "R7 R2 masked event polled");
        irq_mode = 2'b01;
        step(24'h000004, 0, 0, 0, '0, 0, '0, 1, "R7 R8 enabled event");
        swr(24'h00000C, "R7 condition drops");
        irq_mode = 2'b11;
        idle(3, "R9 rise idle");
        step(24'h000004, 0, 0, 0, '0, 0, '0, 1, "R9 rise trigger");
        idle(7, "R9 rise pulse");
        swr(24'h000004, "R9 drop");
        irq_mode = 2'b10;
        idle(3, "R9 fall idle");
        step(24'h000004, 0, 0, 0, '0, 0, '0, 1, "R9 fall trigger");
        idle(7, "R9 fall pulse, no retrigger");
        step('0, 0, 0, 1, 24'hFFFFFF, 1, 24'h000020, 0, "R10 mask watchdog");
        irq_mode = 2'b01;
        step('0, 0, 0, 0, '0, 0, '0, 1, "R10 restart");
        idle(20, "R10 quiet");
        step('0, 0, 0, 0, '0, 0, '0, 1, "R10 read restarts");
        idle(LIM + 3, "R10 expiry");
        swr(24'h000020, "R11 clear refused");
        step('0, 0, 0, 0, '0, 0, '0, 1, "R11 read");
        swr(24'h000020, "R11 clear accepted");
        idle(4, "R11 settle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule